// File: doc/BRIEF.md
# Multi-Source Reset Sequencer

This block produces the internal reset and readiness signals of a network transceiver-style device. Three sources can start a reset: a power-on detect input, an active-low external reset pin, and a one-cycle write strobe that software raises when it sets the self-clearing reset bit of the control register. The pin passes through a two-flop synchroniser and a minimum-width filter, so short glitches never reset the device. While the power-on hold runs, the pin and software writes are ignored.

When a reset is released, the block brings the device up in two phases. After a short fixed count it flags the management port ready. After a much longer, parameterised count it flags the transmit and receive clocks valid, and that flag enables the MAC-side data path. A reset from any source that arrives during the release sequence starts the sequence again from the beginning. While a reset is in effect, a defaults-load output stays high so that every register returns to its reset value. All outputs are registered. `por_i` is also the synchronous active-high reset of the block's own flops.

Top module: `rst_sequencer`

## Requirements
- R1: Cycles are counted in samples of the synchronised pin. When `rst_pin_n_i` has been low for MIN_LOW (default 5) consecutive samples, a reset starts. A shorter low pulse leaves all outputs unchanged.
- R2: Take edge A as the first clock edge that samples the pin high again after a pin reset. `mgmt_ready_o` rises PH1_CYCLES+2 clock edges after edge A. The +2 covers the synchroniser and the release step.
- R3: `clk_valid_o` rises CLKV_CYCLES+2 edges after edge A. This is later than `mgmt_ready_o`, because CLKV_CYCLES is greater than PH1_CYCLES.
- R4: `clk_valid_o` is never high while `mgmt_ready_o` is low.
- R5: The flops reset while `por_i` is high. After `por_i` falls, the release sequence starts at the POR_CYCLES-th edge with `por_i` low. `mgmt_ready_o` then rises POR_CYCLES+PH1_CYCLES edges after the fall, and `clk_valid_o` rises POR_CYCLES+CLKV_CYCLES edges after the fall.
- R6: During the power-on hold, the external pin is ignored. A low pulse of any length that ends inside the hold does not change the release timing.
- R7: A `sw_rst_wr_i` pulse while the sequence runs or is complete is taken at the next edge. For exactly one cycle after that edge, `sw_rst_bit_o` reads 1 and `dflt_load_o` is high. `mgmt_ready_o` returns PH1_CYCLES+1 edges after the write edge, and `clk_valid_o` returns CLKV_CYCLES+1 edges after it.
- R8: `sw_rst_bit_o` reads 0 throughout pin resets and power-on resets.
- R9: `dflt_load_o` is high in every reset state, and in those states `mgmt_ready_o` and `clk_valid_o` are low. Straight after `por_i` the outputs read dflt_load=1, mgmt_ready=0, clk_valid=0, sw_rst_bit=0.
- R10: A pin reset or software reset that arrives before `clk_valid_o` has risen restarts the release count. The earlier clock-valid point then passes with `clk_valid_o` still low.
- R11: A software write that arrives during the power-on hold or while a pin reset is held is ignored. `sw_rst_bit_o` stays 0 and the release timing is unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Reference clock |
| por_i | input | 1 | Power-on detect, active high; also the synchronous reset of the block |
| rst_pin_n_i | input | 1 | External reset pin, active low, asynchronous |
| sw_rst_wr_i | input | 1 | One-cycle strobe: software writes 1 to the reset control bit |
| dflt_load_o | output | 1 | High while registers must load their defaults |
| mgmt_ready_o | output | 1 | Management port may operate |
| clk_valid_o | output | 1 | Transmit and receive clocks valid; MAC data path enabled |
| sw_rst_bit_o | output | 1 | Readback of the self-clearing software reset bit |

## Verification
The assertions assume that `por_i` is high from time zero and through the first clock edges. They also assume that `sw_rst_wr_i` is a single-cycle strobe and that CLKV_CYCLES exceeds PH1_CYCLES, which in turn exceeds zero. The stimulus changes the pin, the strobe and the power-on input only at falling clock edges, which keeps the synchroniser latency fixed so that the expected edge numbers are exact. Software strobes last one cycle. The chosen parameter values keep every restart inside the window before the clocks become valid.

// File: rtl/rstseq_pkg.sv
package rstseq_pkg;
  typedef enum logic [1:0] {
    ST_POR  = 2'd0,
    ST_HOLD = 2'd1,
    ST_REL  = 2'd2,
    ST_RUN  = 2'd3
  } rs_state_e;
endpackage

// File: rtl/rs_pin_sync.sv
module rs_pin_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic por_i,
  input  logic pin_n_i,
  output logic pin_low_o
);
  logic [STAGES-1:0] sh_q;

  always_ff @(posedge clk_i) begin
    if (por_i) sh_q <= '1;
    else       sh_q <= {sh_q[STAGES-2:0], pin_n_i};
  end

  assign pin_low_o = ~sh_q[STAGES-1];
endmodule

// File: rtl/rs_width_filter.sv
module rs_width_filter #(
  parameter int MIN_LOW = 5
) (
  input  logic clk_i,
  input  logic por_i,
  input  logic hold_i,
  input  logic pin_low_i,
  output logic hit_o
);
  localparam int CW = $clog2(MIN_LOW + 1);
  localparam logic [CW-1:0] LAST = CW'(MIN_LOW - 1);

  logic [CW-1:0] run_q;

  always_ff @(posedge clk_i) begin
    if (por_i || hold_i || !pin_low_i) run_q <= '0;
    else if (run_q != LAST)            run_q <= run_q + CW'(1);
  end

  assign hit_o = pin_low_i && !hold_i && (run_q == LAST);

  AST_HIT_AFTER_LOW: assert property (@(posedge clk_i) disable iff (por_i)
    hit_o |-> $past(pin_low_i)); // R1
  AST_HOLD_MASKS_PIN: assert property (@(posedge clk_i) disable iff (por_i)
    hold_i |-> !hit_o); // R6
endmodule

// File: rtl/rs_seq_core.sv
module rs_seq_core
  import rstseq_pkg::*;
#(
  parameter int POR_CYCLES  = 500,
  parameter int PH1_CYCLES  = 16,
  parameter int CLKV_CYCLES = 1325000
) (
  input  logic clk_i,
  input  logic por_i,
  input  logic hit_i,
  input  logic pin_low_i,
  input  logic sw_wr_i,
  output logic in_por_o,
  output logic dflt_load_o,
  output logic mgmt_ready_o,
  output logic clk_valid_o,
  output logic sw_bit_o
);
  localparam int MAXC = (CLKV_CYCLES > POR_CYCLES) ? CLKV_CYCLES : POR_CYCLES;
  localparam int CW   = $clog2(MAXC + 1);
  localparam logic [CW-1:0] POR_LAST  = CW'(POR_CYCLES - 1);
  localparam logic [CW-1:0] CLKV_LAST = CW'(CLKV_CYCLES - 1);
  localparam logic [CW-1:0] PH1_MARK  = CW'(PH1_CYCLES);

  rs_state_e     state_q, nxt;
  logic [CW-1:0] cnt_q, ncnt;
  logic          take_sw;

  always_comb begin
    nxt     = state_q;
    ncnt    = cnt_q;
    take_sw = 1'b0;
    unique case (state_q)
      ST_POR: begin
        if (cnt_q == POR_LAST) begin
          nxt  = ST_REL;
          ncnt = '0;
        end else begin
          ncnt = cnt_q + CW'(1);
        end
      end
      ST_HOLD: begin
        if (!pin_low_i) begin
          nxt  = ST_REL;
          ncnt = '0;
        end
      end
      default: begin
        if (hit_i) begin
          nxt  = ST_HOLD;
          ncnt = '0;
        end else if (sw_wr_i) begin
          nxt     = ST_HOLD;
          ncnt    = '0;
          take_sw = 1'b1;
        end else if (state_q == ST_REL) begin
          if (cnt_q == CLKV_LAST) nxt  = ST_RUN;
          else                    ncnt = cnt_q + CW'(1);
        end
      end
    endcase
  end

  always_ff @(posedge clk_i) begin
    if (por_i) begin
      state_q      <= ST_POR;
      cnt_q        <= '0;
      dflt_load_o  <= 1'b1;
      mgmt_ready_o <= 1'b0;
      clk_valid_o  <= 1'b0;
      sw_bit_o     <= 1'b0;
    end else begin
      state_q      <= nxt;
      cnt_q        <= ncnt;
      dflt_load_o  <= (nxt == ST_POR) || (nxt == ST_HOLD);
      mgmt_ready_o <= (nxt == ST_RUN) || ((nxt == ST_REL) && (ncnt >= PH1_MARK));
      clk_valid_o  <= (nxt == ST_RUN);
      sw_bit_o     <= take_sw;
    end
  end

  assign in_por_o = (state_q == ST_POR);

  AST_CLKV_NEEDS_MGMT: assert property (@(posedge clk_i) disable iff (por_i)
    clk_valid_o |-> mgmt_ready_o); // R4
  AST_MGMT_BEFORE_CLKV: assert property (@(posedge clk_i) disable iff (por_i)
    $rose(clk_valid_o) |-> $past(mgmt_ready_o)); // R3
  AST_SWBIT_SELF_CLEAR: assert property (@(posedge clk_i) disable iff (por_i)
    sw_bit_o |=> !sw_bit_o); // R7
  AST_SWBIT_WITH_LOAD: assert property (@(posedge clk_i) disable iff (por_i)
    sw_bit_o |-> dflt_load_o); // R9
  AST_HW_KEEPS_SWBIT_LOW: assert property (@(posedge clk_i) disable iff (por_i)
    (hit_i && !sw_bit_o) |=> !sw_bit_o); // R8
  AST_POR_NOT_TO_HOLD: assert property (@(posedge clk_i) disable iff (por_i)
    (state_q == ST_POR) |=> (state_q != ST_HOLD)); // R6
endmodule

// File: rtl/rst_sequencer.sv
module rst_sequencer #(
  parameter int SYNC_STAGES = 2,
  parameter int MIN_LOW     = 5,
  parameter int POR_CYCLES  = 500,
  parameter int PH1_CYCLES  = 16,
  parameter int CLKV_CYCLES = 1325000
) (
  input  logic clk_i,
  input  logic por_i,
  input  logic rst_pin_n_i,
  input  logic sw_rst_wr_i,
  output logic dflt_load_o,
  output logic mgmt_ready_o,
  output logic clk_valid_o,
  output logic sw_rst_bit_o
);
  logic pin_low, hit, in_por;

  rs_pin_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk_i     (clk_i),
    .por_i     (por_i),
    .pin_n_i   (rst_pin_n_i),
    .pin_low_o (pin_low)
  );

  rs_width_filter #(.MIN_LOW(MIN_LOW)) u_filt (
    .clk_i     (clk_i),
    .por_i     (por_i),
    .hold_i    (in_por),
    .pin_low_i (pin_low),
    .hit_o     (hit)
  );

  rs_seq_core #(
    .POR_CYCLES  (POR_CYCLES),
    .PH1_CYCLES  (PH1_CYCLES),
    .CLKV_CYCLES (CLKV_CYCLES)
  ) u_core (
    .clk_i        (clk_i),
    .por_i        (por_i),
    .hit_i        (hit),
    .pin_low_i    (pin_low),
    .sw_wr_i      (sw_rst_wr_i),
    .in_por_o     (in_por),
    .dflt_load_o  (dflt_load_o),
    .mgmt_ready_o (mgmt_ready_o),
    .clk_valid_o  (clk_valid_o),
    .sw_bit_o     (sw_rst_bit_o)
  );
endmodule

// File: tb/rst_sequencer_test.sv
module rst_sequencer_test;
  localparam int MIN_LOW = 5;
  localparam int POR_C   = 20;
  localparam int PH1     = 16;
  localparam int CLKV    = 60;

  logic clk = 1'b0;
  logic por = 1'b1;
  logic pin = 1'b1;
  logic sw  = 1'b0;
  logic dflt, mgmt, clkv, swbit;

  int cyc = 0;
  int checks = 0;
  int fails = 0;
  bit done = 1'b0;

  typedef struct {
    int         at;
    logic [3:0] exp;
    string      req;
  } item_t;
  item_t q[$];

  always #10 clk = ~clk;

  rst_sequencer #(
    .SYNC_STAGES (2),
    .MIN_LOW     (MIN_LOW),
    .POR_CYCLES  (POR_C),
    .PH1_CYCLES  (PH1),
    .CLKV_CYCLES (CLKV)
  ) uut (
    .clk_i        (clk),
    .por_i        (por),
    .rst_pin_n_i  (pin),
    .sw_rst_wr_i  (sw),
    .dflt_load_o  (dflt),
    .mgmt_ready_o (mgmt),
    .clk_valid_o  (clkv),
    .sw_rst_bit_o (swbit)
  );

  always @(posedge clk) cyc <= cyc + 1;

  // expected vector order: {dflt_load, mgmt_ready, clk_valid, sw_rst_bit}
  task automatic expect_at(int at, logic [3:0] e, string r);
    q.push_back('{at: at, exp: e, req: r});
  endtask

  always @(negedge clk) begin
    logic [3:0] obs;
    obs = {dflt, mgmt, clkv, swbit};
    for (int i = q.size() - 1; i >= 0; i--) begin
      if (q[i].at == cyc) begin
        checks++;
        if (obs !== q[i].exp) begin
          fails++;
          $display("FAIL %s at edge %0d: actual %b expected %b", q[i].req, cyc, obs, q[i].exp);
        end
        q.delete(i);
      end else if (q[i].at < cyc) begin
        checks++;
        fails++;
        $display("FAIL %s at edge %0d: actual unsampled expected %b", q[i].req, q[i].at, q[i].exp);
        q.delete(i);
      end
    end
  end

  task automatic drain();
    while (q.size() > 0) @(negedge clk);
  endtask

  task automatic por_release();
    int c;
    @(negedge clk);
    c = cyc;
    por = 1'b0;
    expect_at(c + 13, 4'b1000, "R11");
    expect_at(c + POR_C - 1, 4'b1000, "R5");
    expect_at(c + POR_C, 4'b0000, "R5");
    expect_at(c + POR_C + PH1 - 1, 4'b0000, "R6");
    expect_at(c + POR_C + PH1, 4'b0100, "R5");
    expect_at(c + POR_C + CLKV - 1, 4'b0100, "R5");
    expect_at(c + POR_C + CLKV, 4'b0110, "R5");
    repeat (2) @(negedge clk);
    pin = 1'b0;
    repeat (8) @(negedge clk);
    pin = 1'b1;
    repeat (2) @(negedge clk);
    sw = 1'b1;
    @(negedge clk);
    sw = 1'b0;
    drain();
  endtask

  task automatic short_pulse(int len);
    int c;
    @(negedge clk);
    c = cyc;
    pin = 1'b0;
    for (int k = 1; k <= len + 6; k++) expect_at(c + k, 4'b0110, "R1");
    repeat (len) @(negedge clk);
    pin = 1'b1;
    drain();
  endtask

  task automatic pin_reset(int len);
    int c, e0;
    @(negedge clk);
    c = cyc;
    e0 = c + len + 3;
    pin = 1'b0;
    expect_at(c + 6, 4'b0110, "R1");
    expect_at(c + 7, 4'b1000, "R1");
    expect_at(c + len + 2, 4'b1000, "R9");
    expect_at(e0, 4'b0000, "R2");
    expect_at(e0 + PH1 - 1, 4'b0000, "R2");
    expect_at(e0 + PH1, 4'b0100, "R2");
    expect_at(e0 + CLKV - 1, 4'b0100, "R3");
    expect_at(e0 + CLKV, 4'b0110, "R3");
    repeat (len) @(negedge clk);
    pin = 1'b1;
    drain();
  endtask

  task automatic soft_reset();
    int c;
    @(negedge clk);
    c = cyc;
    sw = 1'b1;
    expect_at(c + 1, 4'b1001, "R7");
    expect_at(c + 2, 4'b0000, "R7");
    expect_at(c + 2 + PH1 - 1, 4'b0000, "R7");
    expect_at(c + 2 + PH1, 4'b0100, "R7");
    expect_at(c + 2 + CLKV - 1, 4'b0100, "R7");
    expect_at(c + 2 + CLKV, 4'b0110, "R7");
    @(negedge clk);
    sw = 1'b0;
    drain();
  endtask

  task automatic restart_mid();
    int c, c2, c3, e0, e1, e2;
    @(negedge clk);
    c = cyc;
    e0 = c + 2;
    sw = 1'b1;
    expect_at(c + 1, 4'b1001, "R7");
    expect_at(e0 + PH1, 4'b0100, "R10");
    @(negedge clk);
    sw = 1'b0;
    repeat (PH1 + 2) @(negedge clk);
    c2 = cyc;
    e1 = c2 + 2;
    sw = 1'b1;
    expect_at(c2 + 1, 4'b1001, "R10");
    expect_at(e1, 4'b0000, "R10");
    @(negedge clk);
    sw = 1'b0;
    repeat (PH1) @(negedge clk);
    c3 = cyc;
    e2 = c3 + 8;
    pin = 1'b0;
    expect_at(c3 + 7, 4'b1000, "R10");
    expect_at(e0 + CLKV, 4'b0100, "R10");
    expect_at(e1 + CLKV, 4'b0100, "R10");
    expect_at(e2 + PH1, 4'b0100, "R10");
    expect_at(e2 + CLKV - 1, 4'b0100, "R10");
    expect_at(e2 + CLKV, 4'b0110, "R10");
    repeat (5) @(negedge clk);
    pin = 1'b1;
    drain();
  endtask

  task automatic soft_during_pin();
    int c, e0;
    @(negedge clk);
    c = cyc;
    e0 = c + 13;
    pin = 1'b0;
    expect_at(c + 7, 4'b1000, "R8");
    expect_at(c + 9, 4'b1000, "R11");
    expect_at(c + 10, 4'b1000, "R8");
    expect_at(e0, 4'b0000, "R11");
    expect_at(e0 + PH1, 4'b0100, "R11");
    expect_at(e0 + CLKV, 4'b0110, "R11");
    repeat (8) @(negedge clk);
    sw = 1'b1;
    @(negedge clk);
    sw = 1'b0;
    @(negedge clk);
    pin = 1'b1;
    drain();
  endtask

  initial begin
    expect_at(2, 4'b1000, "R9");
    repeat (3) @(negedge clk);
    drain();
    por_release();
    short_pulse(4);
    short_pulse(1);
    pin_reset(5);
    pin_reset(12);
    soft_reset();
    restart_mid();
    soft_during_pin();
    repeat (3) @(negedge clk);
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL all requirements: watchdog actual running expected finished");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end
endmodule